// File: doc/BRIEF.md
# Sector Protection and Identification Unit

This unit holds the write-protection state of an eight-sector flash array and answers identification and protection-status reads. High-voltage conditions on the address line A9, the output-enable pin and the chip-enable pin arrive as digital flags. Together with the address bus they select a protect or an unprotect operation. The operation is then carried out by one timed write-enable pulse. The pulse is counted in clock cycles, and the operation takes effect only when write enable returns high after the minimum width has been reached.

Protection is set one sector at a time. The sector is chosen by the top three address bits. Unprotection clears every sector in one operation, and it is accepted only when all sectors are already protected. A command interpreter presents each program or erase request with its target sector, and the unit permits or refuses it against the current mask. With A9 at high voltage, a normal read returns either a manufacturer/device code pair or the protection status of the addressed sector.

Top module: `sector_guard`

## Requirements
- R1: After reset `prot_mask_o` is 8'h00, meaning all sectors are unprotected.
- R2: With `a9_hv_i`=1, `oe_hv_i`=1 and `ce_hv_i`=0 sampled at the clock edge where `we_n_i` is first seen low, a low pulse lasting at least PROT_CYCLES sampled clocks sets mask bit `addr_i[18:16]` (sampled at that edge) when `we_n_i` returns high. The other bits are unchanged.
- R3: A pulse shorter than its threshold (PROT_CYCLES, or UNPROT_CYCLES for unprotect) leaves the mask unchanged.
- R4: With `a9_hv_i`, `oe_hv_i` and `ce_hv_i` all 1 and `addr_i[6]`, `addr_i[12]` and `addr_i[16]` all 1 at the falling edge, a pulse of at least UNPROT_CYCLES clears all mask bits. If any of those three address bits is 0, the mask is unchanged.
- R5: An unprotect pulse that is otherwise valid leaves the mask unchanged unless the mask is 8'hFF when the pulse completes.
- R6: `pe_grant_o` is 1 when `pe_req_i`=1 and mask bit `pe_sector_i` is 0. It is 0 when that bit is 1, and 0 when there is no request.
- R7: During a read with `addr_i[1]`=0 and `addr_i[6]`=0, `rd_data_o` is 8'h20 when `addr_i[0]`=0 and 8'hE2 when `addr_i[0]`=1. All other address bits are ignored.
- R8: During a read with `addr_i[1]`=1 or `addr_i[6]`=1, `rd_data_o` is 8'h01 if mask bit `addr_i[18:16]` is set and 8'h00 if it is clear.
- R9: A read is active, and `rd_valid_o`=1, only when `ce_n_i`=0, `oe_n_i`=0, `a9_hv_i`=1 and `oe_hv_i`=0. Otherwise `rd_valid_o`=0 and `rd_data_o`=8'h00.
- R10: A write-enable pulse that begins while `a9_hv_i` or `oe_hv_i` is 0 has no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a9_hv_i | input | 1 | High voltage present on A9 |
| oe_hv_i | input | 1 | High voltage present on output enable |
| ce_hv_i | input | 1 | High voltage present on chip enable |
| addr_i | input | 19 | Address bus |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low, sampled |
| pe_req_i | input | 1 | Program/erase request |
| pe_sector_i | input | 3 | Sector targeted by the request |
| pe_grant_o | output | 1 | Request permitted |
| prot_mask_o | output | 8 | Protection mask, bit n is sector n |
| rd_data_o | output | 8 | Identification or status byte |
| rd_valid_o | output | 1 | Readback active |

## Verification
The readback is exercised across a table of addresses. Some entries hold all unrelated bits low and others hold them high, which shows that only A0, A1, A6 and the sector field steer the byte. Status entries cover both protected and unprotected sectors, so a wrong sector decode shows up as a wrong 01h/00h. Pulse lengths are applied at one cycle below each threshold and exactly at it, which separates an off-by-one in the counter from a correct abort. Unprotect is tried with a partial mask, with a missing address qualifier and with a full mask, which separates the refusal paths from the clear.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROT   = 2'd1,
    OP_UNPROT = 2'd2
  } sg_op_e;
endpackage

// File: rtl/sg_pulse_timer.sv
module sg_pulse_timer
  import sg_pkg::*;
#(
  parameter int unsigned PROT_CYCLES   = 10000,
  parameter int unsigned UNPROT_CYCLES = 1000000,
  parameter int unsigned SW            = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_n_i,
  input  sg_op_e        mode_i,
  input  logic [SW-1:0] sector_i,
  output logic          commit_o,
  output sg_op_e        op_o,
  output logic [SW-1:0] sector_o
);
  localparam int unsigned MAXC = (PROT_CYCLES > UNPROT_CYCLES) ? PROT_CYCLES : UNPROT_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 2);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] THR_P   = CW'(PROT_CYCLES);
  localparam logic [CW-1:0] THR_U   = CW'(UNPROT_CYCLES);

  logic          we_q, active_q;
  logic [CW-1:0] cnt_q;
  sg_op_e        op_q;
  logic [SW-1:0] sec_q;
  logic [CW-1:0] thr;

  assign thr      = (op_q == OP_UNPROT) ? THR_U : THR_P;
  assign commit_o = active_q && we_n_i && (cnt_q >= thr);
  assign op_o     = op_q;
  assign sector_o = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q     <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_NONE;
      sec_q    <= '0;
    end else begin
      we_q <= we_n_i;
      if (!active_q) begin
        // start only on a falling edge seen inside a valid mode
        if (we_q && !we_n_i && mode_i != OP_NONE) begin
          active_q <= 1'b1;
          cnt_q    <= CW'(1);
          op_q     <= mode_i;
          sec_q    <= sector_i;
        end
      end else if (we_n_i) begin
        active_q <= 1'b0;  // completes or aborts on rise
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  a_r10_no_start_outside_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && mode_i == OP_NONE) |=> !active_q);
  a_r3_commit_on_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (we_n_i && !we_q));
endmodule

// File: rtl/sg_prot_mask.sv
module sg_prot_mask
  import sg_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned SW          = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  sg_op_e                 op_i,
  input  logic [SW-1:0]          sector_i,
  output logic [NUM_SECTORS-1:0] mask_o
);
  logic [NUM_SECTORS-1:0] mask_q;
  logic                   all_set;

  assign all_set = &mask_q;
  assign mask_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (commit_i) begin
      if (op_i == OP_PROT) mask_q[sector_i] <= 1'b1;
      else if (op_i == OP_UNPROT && all_set) mask_q <= '0;
    end
  end

  a_r3_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(mask_q));
  a_r2_protect_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == OP_PROT) |=> mask_q[$past(sector_i)]);
  a_r4_unprotect_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == OP_UNPROT && all_set) |=> (mask_q == '0));
  a_r5_unprotect_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && op_i == OP_UNPROT && !all_set) |=> $stable(mask_q));
endmodule

// File: rtl/sg_readback.sv
module sg_readback #(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned SW          = 3,
  parameter logic [7:0]  MFR_CODE    = 8'h20,
  parameter logic [7:0]  DEV_CODE    = 8'hE2
) (
  input  logic                   read_en_i,
  input  logic                   a0_i,
  input  logic                   a1_i,
  input  logic                   a6_i,
  input  logic [SW-1:0]          sector_i,
  input  logic [NUM_SECTORS-1:0] mask_i,
  output logic [7:0]             data_o
);
  always_comb begin
    data_o = 8'h00;
    if (read_en_i) begin
      if (!a1_i && !a6_i) data_o = a0_i ? DEV_CODE : MFR_CODE;
      else                data_o = {7'd0, mask_i[sector_i]};
    end
  end

  always_comb begin
    a_r9_quiet_when_idle: assert (read_en_i || data_o == 8'h00);
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int unsigned NUM_SECTORS   = 8,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned PROT_CYCLES   = 10000,
  parameter int unsigned UNPROT_CYCLES = 1000000,
  parameter logic [7:0]  MFR_CODE      = 8'h20,
  parameter logic [7:0]  DEV_CODE      = 8'hE2,
  localparam int unsigned SW           = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   a9_hv_i,
  input  logic                   oe_hv_i,
  input  logic                   ce_hv_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   ce_n_i,
  input  logic                   oe_n_i,
  input  logic                   we_n_i,
  input  logic                   pe_req_i,
  input  logic [SW-1:0]          pe_sector_i,
  output logic                   pe_grant_o,
  output logic [NUM_SECTORS-1:0] prot_mask_o,
  output logic [7:0]             rd_data_o,
  output logic                   rd_valid_o
);
  // qualifier pins for the unprotect mode
  localparam int unsigned UQ_A = 6;
  localparam int unsigned UQ_B = 12;
  localparam int unsigned UQ_C = 16;

  sg_op_e        mode, op;
  logic          commit;
  logic [SW-1:0] addr_sector, op_sector;

  assign addr_sector = addr_i[ADDR_W-1 -: SW];

  always_comb begin
    mode = OP_NONE;
    if (a9_hv_i && oe_hv_i) begin
      if (!ce_hv_i) mode = OP_PROT;
      else if (addr_i[UQ_A] && addr_i[UQ_B] && addr_i[UQ_C]) mode = OP_UNPROT;
    end
  end

  sg_pulse_timer #(
    .PROT_CYCLES  (PROT_CYCLES),
    .UNPROT_CYCLES(UNPROT_CYCLES),
    .SW           (SW)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_n_i  (we_n_i),
    .mode_i  (mode),
    .sector_i(addr_sector),
    .commit_o(commit),
    .op_o    (op),
    .sector_o(op_sector)
  );

  sg_prot_mask #(
    .NUM_SECTORS(NUM_SECTORS),
    .SW         (SW)
  ) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .op_i    (op),
    .sector_i(op_sector),
    .mask_o  (prot_mask_o)
  );

  assign rd_valid_o = !ce_n_i && !oe_n_i && a9_hv_i && !oe_hv_i;

  sg_readback #(
    .NUM_SECTORS(NUM_SECTORS),
    .SW         (SW),
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE)
  ) i_readback (
    .read_en_i(rd_valid_o),
    .a0_i     (addr_i[0]),
    .a1_i     (addr_i[1]),
    .a6_i     (addr_i[6]),
    .sector_i (addr_sector),
    .mask_i   (prot_mask_o),
    .data_o   (rd_data_o)
  );

  assign pe_grant_o = pe_req_i && !prot_mask_o[pe_sector_i];

  a_r6_protected_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req_i && prot_mask_o[pe_sector_i]) |-> !pe_grant_o);
  a_r6_no_req_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_req_i |-> !pe_grant_o);
endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;
  localparam int unsigned PC = 8;
  localparam int unsigned UC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a9_hv = 1'b0, oe_hv = 1'b0, ce_hv = 1'b0;
  logic [18:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        pe_req = 1'b0;
  logic [2:0]  pe_sec = '0;
  logic        grant, rd_valid;
  logic [7:0]  mask, rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sector_guard #(.PROT_CYCLES(PC), .UNPROT_CYCLES(UC)) i_sector_guard (
    .clk_i(clk), .rst_ni(rst_n), .a9_hv_i(a9_hv), .oe_hv_i(oe_hv), .ce_hv_i(ce_hv),
    .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .pe_req_i(pe_req), .pe_sector_i(pe_sec), .pe_grant_o(grant),
    .prot_mask_o(mask), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  typedef struct packed {
    logic [18:0] addr;
    logic [7:0]  exp;
  } rd_vec_t;

  // mask 8'h89 (sectors 0,3,7) is in place while this table is walked
  localparam rd_vec_t RD_TBL [12] = '{
    '{19'h00000, 8'h20}, '{19'h00001, 8'hE2},
    '{19'h7FFBC, 8'h20}, '{19'h7FFBD, 8'hE2},
    '{19'h00002, 8'h01}, '{19'h30002, 8'h01},
    '{19'h10002, 8'h00}, '{19'h70002, 8'h01},
    '{19'h60002, 8'h00}, '{19'h00040, 8'h01},
    '{19'h50040, 8'h00}, '{19'h20042, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic a9, input logic oe, input logic ce,
                       input logic [18:0] a, input int len);
    @(negedge clk);
    a9_hv = a9; oe_hv = oe; ce_hv = ce; addr = a;
    @(negedge clk);
    we_n = 1'b0;
    repeat (len) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    a9_hv = 1'b0; oe_hv = 1'b0; ce_hv = 1'b0; addr = '0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mask", 32'(mask), 32'h00);
    pe_req = 1'b1; pe_sec = 3'd0;
    #1 check("R6 grant unprotected", 32'(grant), 32'd1);
    pe_req = 1'b0;
    #1 check("R6 no request", 32'(grant), 32'd0);

    pulse(1'b0, 1'b0, 1'b0, 19'h30000, UC + 5);
    check("R10 no mode", 32'(mask), 32'h00);
    pulse(1'b1, 1'b0, 1'b0, 19'h30000, UC + 5);
    check("R10 oe flag low", 32'(mask), 32'h00);

    pulse(1'b1, 1'b1, 1'b0, 19'h30000, PC - 1);
    check("R3 short protect", 32'(mask), 32'h00);
    pulse(1'b1, 1'b1, 1'b0, 19'h30000, PC);
    check("R2 protect s3", 32'(mask), 32'h08);
    pulse(1'b1, 1'b1, 1'b0, 19'h00000, PC);
    pulse(1'b1, 1'b1, 1'b0, 19'h7FFFF, PC + 3);
    check("R2 protect s0 s7", 32'(mask), 32'h89);

    pulse(1'b1, 1'b1, 1'b1, 19'h11040, UC);
    check("R5 unprotect refused", 32'(mask), 32'h89);

    @(negedge clk);
    a9_hv = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      addr = RD_TBL[i].addr;
      #1;
      check("R9 read valid", 32'(rd_valid), 32'd1);
      if (RD_TBL[i].addr[1] || RD_TBL[i].addr[6])
        check("R8 status", 32'(rd_data), 32'(RD_TBL[i].exp));
      else
        check("R7 signature", 32'(rd_data), 32'(RD_TBL[i].exp));
      @(negedge clk);
    end
    oe_n = 1'b1; #1;
    check("R9 oe high valid", 32'(rd_valid), 32'd0);
    check("R9 oe high data", 32'(rd_data), 32'h00);
    oe_n = 1'b0; oe_hv = 1'b1; #1;
    check("R9 oe hv data", 32'(rd_data), 32'h00);
    oe_hv = 1'b0; a9_hv = 1'b0; #1;
    check("R9 no a9", 32'(rd_valid), 32'd0);
    ce_n = 1'b1; oe_n = 1'b1; addr = '0;

    pe_req = 1'b1; pe_sec = 3'd3; #1;
    check("R6 deny s3", 32'(grant), 32'd0);
    pe_sec = 3'd1; #1;
    check("R6 grant s1", 32'(grant), 32'd1);
    pe_req = 1'b0;

    for (int s = 1; s < 7; s++)
      if (s != 3) pulse(1'b1, 1'b1, 1'b0, 19'(s) << 16, PC);
    check("R2 all protected", 32'(mask), 32'hFF);

    pulse(1'b1, 1'b1, 1'b1, 19'h10040, UC + 2);
    check("R4 missing A12", 32'(mask), 32'hFF);
    pulse(1'b1, 1'b1, 1'b1, 19'h11040, UC - 1);
    check("R3 short unprotect", 32'(mask), 32'hFF);
    pulse(1'b1, 1'b1, 1'b1, 19'h11040, UC);
    check("R4 unprotect clears", 32'(mask), 32'h00);

    pulse(1'b1, 1'b1, 1'b0, 19'h50000, PC);
    check("R2 protect s5", 32'(mask), 32'h20);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", 32'(mask), 32'h00);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule